// File: doc/BRIEF.md
# SPI FIFO Status and DMA Request Controller

This block sits between a register bus and a serial shift engine. It holds a transmit queue and a receive queue of 32-bit words. It keeps one status word that reports queue occupancy and sticky error flags. It also raises DMA requests and an interrupt. Software, or a DMA engine, writes words into the transmit queue and reads words out of the receive queue. The serial engine pops transmit words and pushes received words through a plain strobe interface. The serial engine itself is not part of this block.

The status word packs the empty and full flags, the free-slot and filled-slot counts, and the error bits into fixed bit positions. The underflow and overflow flags are sticky and clear when 1 is written to them. The same status word also carries two flush strobes, one for each queue. A control word holds a 2-bit trigger code for each direction, with codes 0/1/2/3 meaning thresholds of 1/4/8/16 words. It also holds one interrupt enable for each direction and a DMA-mode bit. Setting the DMA-mode bit starts a block of N words, where N is taken from a length register. The DMA-mode bit clears itself when the engine has consumed the last word of the block.

The bus is a valid/ready port with `reg_ready_o` tied high. Every request is accepted in the cycle in which `reg_valid_i` is high. For a read, `reg_rdata_o` is valid combinationally in that same cycle, and any pop takes effect at the closing clock edge. Register word addresses are: 0 status, 1 control, 2 block length (16 bits), 3 transmit data (write-only; it reads as 0), and 4 receive data (read-only; writes are ignored).

Top module: `spi_fifo_ctrl`

## Requirements
- R1: Each queue holds 64 words of 32 bits and returns them in the order they entered. Transmit words enter through bus writes to address 3 and leave on `eng_tx_data_o`. Receive words enter through `eng_rx_push_i` and leave through bus reads of address 4.
- R2: The status word (address 0) flags are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full. After reset the status reads 0x0040_0005.
- R3: Status bits 22:16 hold the number of free transmit slots, so an empty queue reads 64. Status bits 29:23 hold the number of filled receive slots.
- R4: A bus write to a full transmit queue drops the data and sets transmit overflow (bit 7). The queue contents are unchanged.
- R5: A bus read of an empty receive queue returns 0 and sets receive underflow (bit 4).
- R6: An engine pop of an empty transmit queue sets transmit underflow (bit 6). An engine push to a full receive queue sets receive overflow (bit 5) and drops the word.
- R7: Bit 8 sets whenever any of bits 4 to 7 sets. Bits 4 to 8 and bit 30 are sticky, and each clears only when 1 is written to it at address 0. Writing to bits 0 to 3 and 16 to 29 has no effect.
- R8: Writing 1 to status bit 14 empties the transmit queue. Writing 1 to status bit 15 empties the receive queue. Neither flush touches the other queue.
- R9: The control word (address 1) has these fields: transmit trigger at bits 16:15, receive trigger at bits 20:19, transmit interrupt enable at bit 28, receive interrupt enable at bit 29, and DMA mode at bit 31. Only these bits read back. A trigger code c gives a threshold of 1 for c=0 and 2<<c otherwise.
- R10: `tx_dma_req_o` is high exactly when DMA mode is on, the free transmit slots are at least the transmit threshold, and fewer than N transmit words have been written since the start.
- R11: `rx_dma_req_o` is high exactly when DMA mode is on and the filled receive slots are at least the receive threshold.
- R12: Writing the control word with bit 31 set loads N from address 2. When the engine makes its Nth transmit pop, the block sets status bit 30 (block complete) and clears control bit 31.
- R13: `irq_o` is the OR of three terms: bit 28 AND (bit 6 OR bit 7); bit 29 AND (bit 4 OR bit 5); and (bit 28 OR bit 29) AND status bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Bus request valid |
| reg_ready_o | output | 1 | Bus ready, always high |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the request cycle |
| eng_tx_pop_i | input | 1 | Engine takes one transmit word |
| eng_tx_data_o | output | 32 | Head of the transmit queue |
| eng_rx_push_i | input | 1 | Engine delivers one receive word |
| eng_rx_data_i | input | 32 | Received word |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest behaviour to reach is the DMA request level at each of the four trigger codes, right at the occupancy where it switches. This needs a queue stepped one word at a time through all 64 levels while DMA mode stays on. The bench sweeps every trigger code for both directions, filling the queue word by word and comparing the request against the threshold worked out arithmetically after every step. It also drives a short block so that the remaining-word count, not the free space, is what drops the transmit request. The full and empty error cases are reached by filling each queue to exactly 64 words and then pushing once more.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_CTRL = 3'd1,
    A_BLEN = 3'd2,
    A_TXD  = 3'd3,
    A_RXD  = 3'd4
  } reg_addr_e;

  localparam int unsigned B_RX_EMPTY = 0;
  localparam int unsigned B_RX_FULL  = 1;
  localparam int unsigned B_TX_EMPTY = 2;
  localparam int unsigned B_TX_FULL  = 3;
  localparam int unsigned B_RX_UNF   = 4;
  localparam int unsigned B_RX_OVF   = 5;
  localparam int unsigned B_TX_UNF   = 6;
  localparam int unsigned B_TX_OVF   = 7;
  localparam int unsigned B_ERR      = 8;
  localparam int unsigned B_TX_FLUSH = 14;
  localparam int unsigned B_RX_FLUSH = 15;
  localparam int unsigned B_TX_FREE  = 16;
  localparam int unsigned B_RX_FILL  = 23;
  localparam int unsigned B_DONE     = 30;
  localparam int unsigned CNT_FW     = 7;

  localparam int unsigned C_TX_TRIG  = 15;
  localparam int unsigned C_RX_TRIG  = 19;
  localparam int unsigned C_IE_TX    = 28;
  localparam int unsigned C_IE_RX    = 29;
  localparam int unsigned C_DMA      = 31;

  function automatic logic [4:0] trig_to_thr(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/spi_xfer_track.sv
module spi_xfer_track #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             active_i,
  input  logic             tx_push_i,
  input  logic             tx_pop_i,
  input  logic [CW-1:0]    tx_free_i,
  input  logic [CW-1:0]    rx_count_i,
  input  logic [CW-1:0]    tx_thr_i,
  input  logic [CW-1:0]    rx_thr_i,
  output logic             tx_req_o,
  output logic             rx_req_o,
  output logic             done_o
);
  // fill_q: words still to be loaded; send_q: words still to be consumed by the engine
  logic [LEN_W-1:0] fill_q, send_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      send_q <= '0;
    end else if (start_i) begin
      fill_q <= len_i;
      send_q <= len_i;
    end else begin
      if (active_i && tx_push_i && fill_q != '0) fill_q <= fill_q - 1'b1;
      if (active_i && tx_pop_i && send_q != '0)  send_q <= send_q - 1'b1;
    end
  end

  assign tx_req_o = active_i && (fill_q != '0) && (tx_free_i >= tx_thr_i);
  assign rx_req_o = active_i && (rx_count_i >= rx_thr_i);
  assign done_o   = active_i && tx_pop_i && !start_i && (send_q == LEN_W'(1));
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  output logic              reg_ready_o,
  input  logic              reg_write_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [DATA_W-1:0] eng_tx_data_o,
  input  logic              eng_rx_push_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic wr_en, rd_en;
  logic wr_stat, wr_ctrl, wr_blen, wr_txd, rd_rxd;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_push, rx_pop, tx_flush, rx_flush;
  logic [DATA_W-1:0] rx_head;

  logic [1:0] tx_trig_q, rx_trig_q;
  logic ie_tx_q, ie_rx_q, dma_en_q;
  logic [LEN_W-1:0] blen_q;
  logic rx_unf_q, rx_ovf_q, tx_unf_q, tx_ovf_q, err_q, done_q;
  logic set_rx_unf, set_rx_ovf, set_tx_unf, set_tx_ovf, done_pulse, start;
  logic [DATA_W-1:0] stat_w, ctrl_w;

  assign reg_ready_o = 1'b1;
  assign wr_en   = reg_valid_i && reg_write_i;
  assign rd_en   = reg_valid_i && !reg_write_i;
  assign wr_stat = wr_en && (reg_addr_i == A_STAT);
  assign wr_ctrl = wr_en && (reg_addr_i == A_CTRL);
  assign wr_blen = wr_en && (reg_addr_i == A_BLEN);
  assign wr_txd  = wr_en && (reg_addr_i == A_TXD);
  assign rd_rxd  = rd_en && (reg_addr_i == A_RXD);

  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign tx_free  = CW'(DEPTH) - tx_cnt;

  assign tx_flush = wr_stat && reg_wdata_i[B_TX_FLUSH];
  assign rx_flush = wr_stat && reg_wdata_i[B_RX_FLUSH];
  assign tx_push  = wr_txd && !tx_full;
  assign tx_pop   = eng_tx_pop_i && !tx_empty;
  assign rx_push  = eng_rx_push_i && !rx_full;
  assign rx_pop   = rd_rxd && !rx_empty;

  assign set_tx_ovf = wr_txd && tx_full;
  assign set_tx_unf = eng_tx_pop_i && tx_empty;
  assign set_rx_ovf = eng_rx_push_i && rx_full;
  assign set_rx_unf = rd_rxd && rx_empty;

  spi_sfifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .flush_i (tx_flush),
    .push_i  (tx_push),
    .pop_i   (tx_pop),
    .wdata_i (reg_wdata_i),
    .rdata_o (eng_tx_data_o),
    .count_o (tx_cnt)
  );

  spi_sfifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .flush_i (rx_flush),
    .push_i  (rx_push),
    .pop_i   (rx_pop),
    .wdata_i (eng_rx_data_i),
    .rdata_o (rx_head),
    .count_o (rx_cnt)
  );

  assign start = wr_ctrl && reg_wdata_i[C_DMA];

  spi_xfer_track #(.LEN_W(LEN_W), .CW(CW)) u_track (
    .clk_i, .rst_ni,
    .start_i    (start),
    .len_i      (blen_q),
    .active_i   (dma_en_q),
    .tx_push_i  (tx_push),
    .tx_pop_i   (tx_pop),
    .tx_free_i  (tx_free),
    .rx_count_i (rx_cnt),
    .tx_thr_i   (CW'(trig_to_thr(tx_trig_q))),
    .rx_thr_i   (CW'(trig_to_thr(rx_trig_q))),
    .tx_req_o   (tx_dma_req_o),
    .rx_req_o   (rx_dma_req_o),
    .done_o     (done_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_trig_q <= '0;
      rx_trig_q <= '0;
      ie_tx_q   <= 1'b0;
      ie_rx_q   <= 1'b0;
      dma_en_q  <= 1'b0;
      blen_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_trig_q <= reg_wdata_i[C_TX_TRIG +: 2];
        rx_trig_q <= reg_wdata_i[C_RX_TRIG +: 2];
        ie_tx_q   <= reg_wdata_i[C_IE_TX];
        ie_rx_q   <= reg_wdata_i[C_IE_RX];
        dma_en_q  <= reg_wdata_i[C_DMA];
      end else if (done_pulse) begin
        dma_en_q  <= 1'b0;
      end
      if (wr_blen) blen_q <= reg_wdata_i[LEN_W-1:0];
    end
  end

  // sticky flags: a new event in the same cycle wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_unf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      tx_unf_q <= 1'b0;
      tx_ovf_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      rx_unf_q <= set_rx_unf | (rx_unf_q & ~(wr_stat & reg_wdata_i[B_RX_UNF]));
      rx_ovf_q <= set_rx_ovf | (rx_ovf_q & ~(wr_stat & reg_wdata_i[B_RX_OVF]));
      tx_unf_q <= set_tx_unf | (tx_unf_q & ~(wr_stat & reg_wdata_i[B_TX_UNF]));
      tx_ovf_q <= set_tx_ovf | (tx_ovf_q & ~(wr_stat & reg_wdata_i[B_TX_OVF]));
      err_q    <= (set_rx_unf | set_rx_ovf | set_tx_unf | set_tx_ovf)
                | (err_q & ~(wr_stat & reg_wdata_i[B_ERR]));
      done_q   <= done_pulse | (done_q & ~(wr_stat & reg_wdata_i[B_DONE]));
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[B_RX_EMPTY] = rx_empty;
    stat_w[B_RX_FULL]  = rx_full;
    stat_w[B_TX_EMPTY] = tx_empty;
    stat_w[B_TX_FULL]  = tx_full;
    stat_w[B_RX_UNF]   = rx_unf_q;
    stat_w[B_RX_OVF]   = rx_ovf_q;
    stat_w[B_TX_UNF]   = tx_unf_q;
    stat_w[B_TX_OVF]   = tx_ovf_q;
    stat_w[B_ERR]      = err_q;
    stat_w[B_TX_FREE +: CNT_FW] = CNT_FW'(tx_free);
    stat_w[B_RX_FILL +: CNT_FW] = CNT_FW'(rx_cnt);
    stat_w[B_DONE]     = done_q;
  end

  always_comb begin
    ctrl_w = '0;
    ctrl_w[C_TX_TRIG +: 2] = tx_trig_q;
    ctrl_w[C_RX_TRIG +: 2] = rx_trig_q;
    ctrl_w[C_IE_TX]        = ie_tx_q;
    ctrl_w[C_IE_RX]        = ie_rx_q;
    ctrl_w[C_DMA]          = dma_en_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (rd_en) begin
      case (reg_addr_i)
        A_STAT:  reg_rdata_o = stat_w;
        A_CTRL:  reg_rdata_o = ctrl_w;
        A_BLEN:  reg_rdata_o = DATA_W'(blen_q);
        A_RXD:   reg_rdata_o = rx_empty ? '0 : rx_head;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (ie_tx_q & (tx_unf_q | tx_ovf_q))
               | (ie_rx_q & (rx_unf_q | rx_ovf_q))
               | ((ie_tx_q | ie_rx_q) & done_q);
endmodule

// File: rtl/spi_fifo_ctrl_chk.sv
module spi_fifo_ctrl_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_valid_i,
  input logic          reg_write_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [31:0]   reg_rdata_o,
  input logic          irq_o,
  input logic          tx_dma_req_o,
  input logic          rx_dma_req_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_ovf_q,
  input logic          ie_tx_q,
  input logic          ie_rx_q,
  input logic          dma_en_q
);
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_rx_unf_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i && reg_addr_i == 3'd4 && rx_cnt == '0) |-> (reg_rdata_o == 32'd0));

  p_tx_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_q && !(reg_valid_i && reg_write_i && reg_addr_i == 3'd0 && reg_wdata_i[7])) |=> tx_ovf_q);

  p_tx_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && reg_addr_i == 3'd0 && reg_wdata_i[14]) |=> (tx_cnt == '0));

  p_tx_req_room_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (dma_en_q && tx_cnt < CW'(DEPTH)));

  p_rx_req_dma_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (dma_en_q && rx_cnt != '0));

  p_irq_gate_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_tx_q && !ie_rx_q) |-> !irq_o);
endmodule

bind spi_fifo_ctrl spi_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_valid_i  (reg_valid_i),
  .reg_write_i  (reg_write_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .tx_dma_req_o (tx_dma_req_o),
  .rx_dma_req_o (rx_dma_req_o),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .tx_ovf_q     (tx_ovf_q),
  .ie_tx_q      (ie_tx_q),
  .ie_rx_q      (ie_rx_q),
  .dma_en_q     (dma_en_q)
);

// File: tb/spi_fifo_ctrl_bench.sv
module spi_fifo_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, eng_tx_data;
  logic reg_ready, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic tx_req, rx_req, irq;

  int total = 0, failed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_ctrl u_spi_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_valid_i(reg_valid), .reg_ready_o(reg_ready), .reg_write_i(reg_write),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_pop_i(eng_tx_pop), .eng_tx_data_o(eng_tx_data),
    .eng_rx_push_i(eng_rx_push), .eng_rx_data_i(eng_rx_data),
    .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic eng_pop(output logic [31:0] d);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    #1 d = eng_tx_data;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  function automatic int thr_of(input int code);
    return (code == 0) ? 1 : (2 << code);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2 R3 reset state
    bus_rd(3'd0, s); check("R2 reset status", s, 32'h0040_0005);
    bus_rd(3'd1, d); check("R9 reset ctrl", d, 32'h0);
    check("R13 reset irq", {31'd0, irq}, 0);
    check("R10 reset tx req", {31'd0, tx_req}, 0);

    // R1 R3 fill transmit queue word by word
    for (int i = 0; i < 64; i++) begin
      bus_wr(3'd3, 32'hA500_0000 + i * 3);
      bus_rd(3'd0, s);
      check("R3 tx free count", (s >> 16) & 32'h7F, 63 - i);
      check("R2 tx empty/full", s & 32'hC, (i == 63) ? 32'h8 : 32'h0);
    end
    // R4 overflow
    bus_wr(3'd3, 32'hDEAD_BEEF);
    bus_rd(3'd0, s);
    check("R4 tx overflow flag", s & 32'h1F0, 32'h180);
    check("R4 tx free after overflow", (s >> 16) & 32'h7F, 0);
    for (int i = 0; i < 64; i++) begin
      eng_pop(d);
      check("R1 tx order", d, 32'hA500_0000 + i * 3);
    end
    bus_rd(3'd0, s); check("R2 tx empty again", s & 32'hC, 32'h4);
    // R6 transmit underflow
    eng_pop(d);
    bus_rd(3'd0, s); check("R6 tx underflow", s & 32'h1F0, 32'h1C0);

    // R7 write-1-to-clear, writes to flag/count bits ignored
    bus_wr(3'd0, 32'h3FFF_00CF);
    bus_rd(3'd0, s); check("R7 partial clear", s, 32'h0040_0105);
    bus_wr(3'd0, 32'h0000_0100);
    bus_rd(3'd0, s); check("R7 err clear", s, 32'h0040_0005);

    // R1 R3 R6 receive fill and overflow
    for (int j = 0; j < 64; j++) begin
      eng_push(32'h5A00_0001 + j * 7);
      bus_rd(3'd0, s);
      check("R3 rx fill count", (s >> 23) & 32'h7F, j + 1);
    end
    check("R2 rx full", s & 32'h3, 32'h2);
    eng_push(32'hFFFF_FFFF);
    bus_rd(3'd0, s); check("R6 rx overflow", s & 32'h1F0, 32'h120);
    for (int j = 0; j < 64; j++) begin
      bus_rd(3'd4, d);
      check("R1 rx order", d, 32'h5A00_0001 + j * 7);
    end
    // R5 receive underflow
    bus_rd(3'd4, d); check("R5 empty read zero", d, 0);
    bus_rd(3'd0, s); check("R5 rx underflow", s & 32'h1F1, 32'h131);
    bus_wr(3'd0, 32'h0000_01F0);

    // R8 flushes are independent
    for (int k = 0; k < 10; k++) begin bus_wr(3'd3, k); eng_push(k); end
    bus_wr(3'd0, 32'h0000_4000);
    bus_rd(3'd0, s);
    check("R8 tx flushed", (s >> 16) & 32'h7F, 64);
    check("R8 rx kept", (s >> 23) & 32'h7F, 10);
    bus_wr(3'd0, 32'h0000_8000);
    bus_rd(3'd0, s); check("R8 rx flushed", s, 32'h0040_0005);

    // R9 control readback
    bus_wr(3'd1, 32'h7FFF_FFFF);
    bus_rd(3'd1, d); check("R9 ctrl fields", d, 32'h3019_8000);
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd2, 32'h0001_00C8);
    bus_rd(3'd2, d); check("R12 length readback", d, 32'h00C8);

    // R10 transmit request sweep per trigger code
    for (int t = 0; t < 4; t++) begin
      bus_wr(3'd0, 32'h0000_4000);
      bus_wr(3'd1, 32'h8000_0000 | (t << 15));
      check("R10 tx req empty queue", {31'd0, tx_req}, 1);
      for (int i = 1; i <= 64; i++) begin
        bus_wr(3'd3, i);
        check("R10 tx req level", {31'd0, tx_req}, ((64 - i) >= thr_of(t)) ? 1 : 0);
      end
    end
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd0, 32'h0000_4000);

    // R11 receive request sweep per trigger code
    for (int t = 0; t < 4; t++) begin
      bus_wr(3'd0, 32'h0000_8000);
      bus_wr(3'd1, 32'h8000_0000 | (t << 19));
      check("R11 rx req empty", {31'd0, rx_req}, 0);
      for (int i = 1; i <= 20; i++) begin
        eng_push(i);
        check("R11 rx req level", {31'd0, rx_req}, (i >= thr_of(t)) ? 1 : 0);
      end
      bus_wr(3'd1, 32'h0000_0000 | (t << 19));
      check("R11 rx req needs dma", {31'd0, rx_req}, 0);
    end
    bus_wr(3'd0, 32'h0000_8000);

    // R10 R12 R13 short block
    bus_wr(3'd2, 3);
    bus_wr(3'd1, 32'h9000_0000);
    for (int i = 0; i < 3; i++) bus_wr(3'd3, 32'hC0DE_0000 + i);
    check("R10 tx req stops at length", {31'd0, tx_req}, 0);
    eng_pop(d); eng_pop(d);
    bus_rd(3'd0, s); check("R12 not done early", s & 32'h4000_0000, 0);
    check("R13 irq before done", {31'd0, irq}, 0);
    eng_pop(d); check("R12 last word", d, 32'hC0DE_0002);
    bus_rd(3'd0, s); check("R12 done flag", s & 32'h4000_0000, 32'h4000_0000);
    bus_rd(3'd1, d); check("R12 dma bit cleared", d, 32'h1000_0000);
    check("R13 irq on done", {31'd0, irq}, 1);
    bus_wr(3'd0, 32'h4000_0000);
    check("R13 irq cleared", {31'd0, irq}, 0);

    // R13 direction gating of errors
    bus_wr(3'd1, 32'h2000_0000);
    eng_pop(d);
    check("R13 tx error masked by rx enable", {31'd0, irq}, 0);
    bus_wr(3'd1, 32'h1000_0000);
    check("R13 tx error with tx enable", {31'd0, irq}, 1);
    bus_wr(3'd0, 32'h0000_01F0);
    check("R13 irq after clear", {31'd0, irq}, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule